// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare channel that sits beside a free-running 16-bit timer counter. The counter value, an update-event strobe and an external capture strobe come in as inputs. Software reaches the channel through a small 8-bit register port. On that port the 16-bit channel value appears as a high byte and a low byte.

In output mode the written value either becomes the active compare value at once or waits in a preload register until the next update event. The channel compares the active value with the counter and drives a PWM-style compare output. In input mode a capture strobe copies the counter into the value register, and software writes to the value are dropped. A capture or a compare match raises a status flag. That flag, gated by an enable bit, forms the interrupt output.

Top module: `ccp_channel`

## Requirements
- R1: While `rst_n` is low and straight after it is released, the value reads 0x00 at both byte addresses, and `cmp_o` and `irq_o` are 0.
- R2: Register addresses are 0 control, 1 interrupt enable, 2 status, 3 value high byte, 4 value low byte. In output mode (control bit 0 = 0) with preload off (control bit 1 = 0), a low-byte write loads the active compare value with {buffered high byte, written low byte} at that clock edge.
- R3: With preload on (control bit 1 = 1), value writes change only the preload register, and the active compare value keeps its old value until an update event.
- R4: With preload on in output mode, an `update_i` pulse copies the preload register into the active compare value.
- R5: One clock after the counter is sampled, `cmp_o` is 1 when the channel is in output mode and the counter is greater than or equal to the active value. Otherwise it is 0, and it is always 0 in input mode (control bit 0 = 1).
- R6: In input mode, a `capture_i` pulse stores the counter value into the value register. The next high and low reads return that value.
- R7: The status flag (status bit 0) is set one clock after a capture in input mode, or one clock after the counter equals the active value in output mode.
- R8: Writing status with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves it unchanged. A set event in the same cycle wins over the clear.
- R9: `irq_o` is 1 exactly when the flag is set and the interrupt-enable bit (enable register bit 0) is 1.
- R10: A high-byte write is buffered and leaves the readable value and the compare value unchanged until the low byte is written.
- R11: A high-byte read latches the low byte in the same cycle. The next low-byte read returns that latched byte, even if a capture happens in between.
- R12: In input mode, writes to either value byte are ignored, and the captured value stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Timer counter value |
| update_i | input | 1 | Update event strobe |
| capture_i | input | 1 | Capture event strobe |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| cmp_o | output | 1 | Registered compare output |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong active compare value shows on `cmp_o` one clock after the counter crosses the intended threshold. A wrong preload or buffered high byte stays hidden until the next update event or low-byte write, so the bench checks the output both before and after those events. A corrupted capture or a stale low-byte latch shows at the very next pair of value reads. A bad flag shows on `irq_o` in the same cycle as the flag.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_IEN  = 3'd1,
        A_STAT = 3'd2,
        A_VALH = 3'd3,
        A_VALL = 3'd4
    } reg_addr_e;

    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_PRE_BIT  = 1;
endpackage

// File: rtl/ccp_value.sv
module ccp_value #(
    parameter int BUS_W = 8,
    localparam int VAL_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_in,
    input  logic             pre_en,
    input  logic             upd,
    input  logic             cap,
    input  logic [VAL_W-1:0] cnt,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [BUS_W-1:0] wdata,
    output logic [VAL_W-1:0] shadow,
    output logic [VAL_W-1:0] active,
    output logic [BUS_W-1:0] hi_buf
);
    typedef struct packed {
        logic [BUS_W-1:0] hi;
        logic [VAL_W-1:0] shd;
        logic [VAL_W-1:0] act;
    } val_state_t;

    val_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!mode_in) begin
            if (wr_hi) st_d.hi = wdata;
            if (wr_lo) begin
                st_d.shd = {st_q.hi, wdata};
                if (!pre_en) st_d.act = {st_q.hi, wdata};
            end
            if (pre_en && upd) st_d.act = st_q.shd;
        end else if (cap) begin
            st_d.shd = cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow = st_q.shd;
    assign active = st_q.act;
    assign hi_buf = st_q.hi;
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_in,
    input  logic [VAL_W-1:0] cnt,
    input  logic [VAL_W-1:0] active,
    output logic             cmp_out,
    output logic             match
);
    typedef struct packed {
        logic cmp;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    always_comb begin
        st_d.cmp = !mode_in && (cnt >= active);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_out = st_q.cmp;
    assign match   = !mode_in && (cnt == active);
endmodule

// File: rtl/ccp_status.sv
module ccp_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_wr,
    input  logic ien,
    output logic flag,
    output logic irq
);
    typedef struct packed {
        logic flg;
    } st_state_t;

    st_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_evt)     st_d.flg = 1'b1;
        else if (clr_wr) st_d.flg = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flg;
    assign irq  = st_q.flg & ien;
endmodule

// File: rtl/ccp_readmux.sv
module ccp_readmux
    import ccp_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int VAL_W = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mode_in,
    input  logic              pre_en,
    input  logic              ien,
    input  logic              flag,
    input  logic [VAL_W-1:0]  shadow,
    output logic [BUS_W-1:0]  rdata
);
    typedef struct packed {
        logic [BUS_W-1:0] lo;
        logic             vld;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en && addr == A_VALH) begin
            st_d.lo  = shadow[BUS_W-1:0];
            st_d.vld = 1'b1;
        end else if (rd_en && addr == A_VALL) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: rdata = {{(BUS_W-2){1'b0}}, pre_en, mode_in};
            A_IEN:  rdata = {{(BUS_W-1){1'b0}}, ien};
            A_STAT: rdata = {{(BUS_W-1){1'b0}}, flag};
            A_VALH: rdata = shadow[VAL_W-1:BUS_W];
            A_VALL: rdata = st_q.vld ? st_q.lo : shadow[BUS_W-1:0];
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
    import ccp_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int VAL_W = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VAL_W-1:0]  cnt_i,
    input  logic              update_i,
    input  logic              capture_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              cmp_o,
    output logic              irq_o
);
    typedef struct packed {
        logic mode;
        logic pre;
        logic ien;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;

    logic             mode_q, pre_q, ien_q;
    logic [VAL_W-1:0] shd_val, act_val;
    logic [BUS_W-1:0] hi_buf;
    logic             match, flag;
    logic             wr_hi, wr_lo, clr_wr, set_evt;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en_i && addr_i == A_CTRL) begin
            ctl_d.mode = wdata_i[CTRL_MODE_BIT];
            ctl_d.pre  = wdata_i[CTRL_PRE_BIT];
        end
        if (wr_en_i && addr_i == A_IEN) ctl_d.ien = wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mode_q  = ctl_q.mode;
    assign pre_q   = ctl_q.pre;
    assign ien_q   = ctl_q.ien;
    assign wr_hi   = wr_en_i && addr_i == A_VALH;
    assign wr_lo   = wr_en_i && addr_i == A_VALL;
    assign clr_wr  = wr_en_i && addr_i == A_STAT && !wdata_i[0];
    assign set_evt = (mode_q && capture_i) || match;

    ccp_value #(.BUS_W(BUS_W)) u_value (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_q), .pre_en(pre_q),
        .upd(update_i), .cap(capture_i), .cnt(cnt_i),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(wdata_i),
        .shadow(shd_val), .active(act_val), .hi_buf(hi_buf)
    );

    ccp_compare #(.VAL_W(VAL_W)) u_compare (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_q), .cnt(cnt_i),
        .active(act_val), .cmp_out(cmp_o), .match(match)
    );

    ccp_status u_status (
        .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_wr(clr_wr),
        .ien(ien_q), .flag(flag), .irq(irq_o)
    );

    ccp_readmux #(.BUS_W(BUS_W)) u_readmux (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en_i), .addr(addr_i),
        .mode_in(mode_q), .pre_en(pre_q), .ien(ien_q), .flag(flag),
        .shadow(shd_val), .rdata(rdata_o)
    );
endmodule

// File: rtl/ccp_channel_chk.sv
module ccp_channel_chk
    import ccp_pkg::*;
#(
    parameter int BUS_W = 8,
    localparam int VAL_W = 2 * BUS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [VAL_W-1:0]  cnt_i,
    input logic              update_i,
    input logic              capture_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [BUS_W-1:0]  wdata_i,
    input logic              cmp_o,
    input logic              mode_q,
    input logic              pre_q,
    input logic [VAL_W-1:0]  shd_val,
    input logic [VAL_W-1:0]  act_val,
    input logic [BUS_W-1:0]  hi_buf,
    input logic              flag
);
    // R2
    p_off_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_VALL && !mode_q && !pre_q)
        |=> act_val == {$past(hi_buf), $past(wdata_i)});

    // R3
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q && !update_i) |=> $stable(act_val));

    // R4
    upd_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && pre_q && update_i) |=> act_val == $past(shd_val));

    // R5
    cmp_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cmp_o == ($past(!mode_q) && ($past(cnt_i) >= $past(act_val))));

    // R6
    cap_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && capture_i) |=> shd_val == $past(cnt_i));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q && capture_i) || (!mode_q && cnt_i == act_val)) |=> flag);

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_STAT && !wdata_i[0] && !(mode_q && capture_i)
         && !(!mode_q && cnt_i == act_val)) |=> !flag);

    // R10
    hi_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !(wr_en_i && addr_i == A_VALL)) |=> $stable(shd_val));

    // R12
    in_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !capture_i) |=> $stable(shd_val));
endmodule

bind ccp_channel ccp_channel_chk #(.BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .update_i(update_i),
    .capture_i(capture_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cmp_o(cmp_o), .mode_q(mode_q), .pre_q(pre_q),
    .shd_val(shd_val), .act_val(act_val), .hi_buf(hi_buf), .flag(flag)
);

// File: tb/ccp_channel_tb.sv
module ccp_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_i = 16'h5555;
    logic        update_i = 1'b0, capture_i = 1'b0;
    logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [2:0]  addr_i = 3'd0;
    logic [7:0]  wdata_i = 8'h00;
    logic [7:0]  rdata_o;
    logic        cmp_o, irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [2:0] CTRL = 3'd0, IEN = 3'd1, STAT = 3'd2, VALH = 3'd3, VALL = 3'd4;

    // {compare value, counter, expected cmp_o}
    localparam int NV = 8;
    localparam logic [32:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 1'b1},
        {16'h8000, 16'h7FFF, 1'b0},
        {16'h8000, 16'h8000, 1'b1},
        {16'hFFFF, 16'hFFFE, 1'b0},
        {16'hFFFF, 16'hFFFF, 1'b1},
        {16'h1234, 16'hFFFF, 1'b1},
        {16'h00FF, 16'h0100, 1'b1},
        {16'h0100, 16'h00FF, 1'b0}
    };

    always #10 clk = ~clk;

    ccp_channel u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .update_i(update_i),
        .capture_i(capture_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .cmp_o(cmp_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        #1 d = rdata_o;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic pulse_upd();
        @(negedge clk); update_i = 1'b1;
        @(negedge clk); update_i = 1'b0;
    endtask

    task automatic pulse_cap();
        @(negedge clk); capture_i = 1'b1;
        @(negedge clk); capture_i = 1'b0;
    endtask

    initial begin
        logic [7:0] d, h;
        repeat (3) @(negedge clk);
        addr_i = VALH;
        #1 check("R1 high byte in reset", {8'h00, rdata_o}, 16'h0000);
        check("R1 cmp_o in reset", {15'd0, cmp_o}, 16'd0);
        check("R1 irq_o in reset", {15'd0, irq_o}, 16'd0);
        @(negedge clk); rst_n = 1'b1;
        rd(VALL, d); check("R1 low byte after reset", {8'h00, d}, 16'h0000);

        // Table: output mode, preload off
        for (int i = 0; i < NV; i++) begin
            wr(VALH, VEC[i][32:25]);
            wr(VALL, VEC[i][24:17]);
            @(negedge clk); cnt_i = VEC[i][16:1];
            @(negedge clk);
            check($sformatf("R5 R2 vector %0d", i), {15'd0, cmp_o}, {15'd0, VEC[i][0]});
        end

        // R10: buffered high byte
        wr(VALH, 8'hAB);
        rd(VALH, d); check("R10 high byte unchanged before low write", {8'h00, d}, 16'h0001);
        wr(VALL, 8'hCD);
        rd(VALH, d); check("R10 high byte committed", {8'h00, d}, 16'h00AB);
        rd(VALL, d); check("R10 low byte committed", {8'h00, d}, 16'h00CD);

        // R3 / R4: preload
        wr(CTRL, 8'h02);
        cnt_i = 16'h9000;
        wr(VALH, 8'h80); wr(VALL, 8'h00);
        @(negedge clk);
        check("R3 active held with preload", {15'd0, cmp_o}, 16'd0);
        pulse_upd();
        @(negedge clk);
        check("R4 update copies preload", {15'd0, cmp_o}, 16'd1);

        // R7 / R8 / R9 flag and interrupt (active = 0x8000)
        cnt_i = 16'h0001;
        wr(STAT, 8'h00);
        rd(STAT, d); check("R8 flag cleared by writing 0", {8'h00, d}, 16'h0000);
        wr(IEN, 8'h01);
        check("R9 irq low while flag clear", {15'd0, irq_o}, 16'd0);
        @(negedge clk); cnt_i = 16'h8000;
        @(negedge clk); cnt_i = 16'h0001;
        rd(STAT, d); check("R7 match sets flag", {8'h00, d}, 16'h0001);
        check("R9 irq with flag and enable", {15'd0, irq_o}, 16'd1);
        wr(STAT, 8'h01);
        rd(STAT, d); check("R8 writing 1 keeps flag", {8'h00, d}, 16'h0001);
        wr(IEN, 8'h00);
        check("R9 irq masked by enable", {15'd0, irq_o}, 16'd0);
        wr(STAT, 8'h00);
        rd(STAT, d); check("R8 flag cleared again", {8'h00, d}, 16'h0000);

        // Input mode
        wr(CTRL, 8'h01);
        @(negedge clk);
        check("R5 cmp_o low in input mode", {15'd0, cmp_o}, 16'd0);
        cnt_i = 16'h1357;
        pulse_cap();
        rd(STAT, d); check("R7 capture sets flag", {8'h00, d}, 16'h0001);
        rd(VALH, h); rd(VALL, d);
        check("R6 captured value", {h, d}, 16'h1357);
        wr(VALH, 8'hFF); wr(VALL, 8'hEE);
        rd(VALH, h); rd(VALL, d);
        check("R12 writes ignored in input mode", {h, d}, 16'h1357);

        // R11: coherent 16-bit read across a capture
        cnt_i = 16'h2468;
        pulse_cap();
        rd(VALH, h);
        cnt_i = 16'h9ABC;
        pulse_cap();
        rd(VALL, d);
        check("R11 low byte latched at high read", {h, d}, 16'h2468);
        rd(VALH, h); rd(VALL, d);
        check("R11 next pair shows new capture", {h, d}, 16'h9ABC);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule